// File: doc/BRIEF.md
# Domain and Sub-Page Access Checker

This block sits next to a memory pipeline and decides, for each access request, whether the access may go ahead. It holds three pieces of state loaded through a register-programming port:

- a small fully associative table of 1 MB section descriptors, each naming the owning domain of its region;
- a domain control word with one 2-bit field per domain for the running task;
- a small fully associative table of 4 KB page descriptors, each carrying four 2-bit permissions, one for each 1 KB quarter of the page.

A request carries a virtual address and a write flag. One cycle later the block answers with a grant, or with a fault. A fault reports its kind and the captured address.

The checks run in a fixed order:

1. A missing section gives a translation fault.
2. A section whose domain field denies access gives a domain fault.
3. A missing page gives a page fault.
4. A sub-page permission that does not allow the access gives a permission fault.

Passing the domain check only allows an attempt; the page permissions then decide between reading and writing. Page-table walking, physical translation and fault handling are outside the block.

Top module: `dom_subpage_checker`

## Requirements
- R1: Every cycle with `req_valid` high is followed, in the next cycle, by exactly one cycle with `rsp_valid` high, and `rsp_addr` then equals the request address. A cycle without a request is followed by `rsp_valid` low.
- R2: If no valid section descriptor has a tag equal to address bits [31:20], the response is a fault with `rsp_kind` = 01 (translation). This check comes before every other check.
- R3: The 4-bit domain of the matching section selects the control-word field at bits [2d+1:2d]. Field value 00 gives a fault with `rsp_kind` = 00 (domain). Values 01, 10 and 11 let the request proceed. The domain check comes before the page lookup.
- R4: If the section and domain checks pass but no valid page descriptor has a tag equal to address bits [31:12], the response is a fault with `rsp_kind` = 10 (page).
- R5: Address bits [11:10] select sub-page k, whose permission sits at bits [2k+1:2k] of the page descriptor. The codes are 00 no-access, 01 read-only, 10 read-write and 11 no-access. A write to a read-only sub-page, or any access to a no-access sub-page, gives a fault with `rsp_kind` = 11 (permission).
- R6: A request that passes every check gives `rsp_grant` = 1 and `rsp_kind` = 00. Reads are granted on read-only and read-write sub-pages. Writes are granted only on read-write sub-pages.
- R7: Programming port writes, selected by `prog_sel`, behave as follows.
  - Value 0 writes the section entry `prog_idx`, using data bits [31:20] as the tag, [4] as the valid bit and [3:0] as the domain.
  - Value 1 writes the domain control word with all 32 data bits.
  - Value 2 writes the page entry `prog_idx`, using data bits [31:12] as the tag, [8] as the valid bit and [7:0] as the permissions.
  - Value 3, or an index beyond the table depth, changes nothing.
  - A write is seen by requests issued in the following cycle. A request issued in the same cycle still sees the old state.
- R8: Synchronous active-low reset clears every descriptor valid bit, sets the domain control word to all no-access and holds `rsp_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| prog_we | input | 1 | Programming write strobe |
| prog_sel | input | 2 | Target: 0 section table, 1 domain control, 2 page table, 3 none |
| prog_idx | input | IDX_W | Table entry index |
| prog_data | input | 32 | Write data, field layout per R7 |
| req_valid | input | 1 | Access request valid |
| req_addr | input | 32 | Virtual address of the access |
| req_write | input | 1 | 1 for a write, 0 for a read |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_grant | output | 1 | 1 when the access is allowed |
| rsp_kind | output | 2 | Fault kind: 00 domain, 01 translation, 10 page, 11 permission |
| rsp_addr | output | 32 | Address captured from the request |

## Verification
The addresses are chosen so that each fault kind is reached while every check before it passes. The translation case uses an unmapped section. The domain case uses a mapped section whose field is 00, with no page loaded, which shows that the domain check outranks the page check. The page case uses a page missing inside a mapped, enabled section. The permission cases read and write all four permission codes in all four quarters of one page, which separates the read-only rule, the read-write rule and the rule that treats 11 as no-access. Further patterns cover the following:

- all three non-zero domain-field codes;
- a second section with its own domain field;
- back-to-back requests;
- a programming write issued in the same cycle as a request and again one cycle before it, which separates old-state and new-state lookups;
- invalidation of a section;
- writes with select 3 or an out-of-range index, which must leave the tables unchanged.

// File: rtl/dom_subpage_checker_pkg.sv
// Package: shared constants and types of the domain and sub-page access checker.
// Assumes a 32-bit virtual address with 1 MB sections, 4 KB pages and 1 KB sub-pages.
package dom_subpage_checker_pkg;

    localparam int ADDR_W      = 32;
    localparam int SECT_SHIFT  = 20;
    localparam int PAGE_SHIFT  = 12;
    localparam int SUB_SHIFT   = 10;
    localparam int SECT_TAG_W  = ADDR_W - SECT_SHIFT;
    localparam int PAGE_TAG_W  = ADDR_W - PAGE_SHIFT;
    localparam int SUB_W       = PAGE_SHIFT - SUB_SHIFT;
    localparam int N_SUB       = 1 << SUB_W;
    localparam int DOM_W       = 4;
    localparam int N_DOM       = 1 << DOM_W;
    localparam int FIELD_W     = 2;
    localparam int DCR_W       = N_DOM * FIELD_W;
    localparam int PERM_W      = 2;
    localparam int PERMS_W     = N_SUB * PERM_W;

    // Sub-page permission codes; 2'b11 behaves as no-access.
    typedef enum logic [PERM_W-1:0] {
        PERM_NONE = 2'b00,
        PERM_RO   = 2'b01,
        PERM_RW   = 2'b10,
        PERM_RSV  = 2'b11
    } perm_e;

    // Fault kinds reported on the response; DOMAIN doubles as the grant value.
    typedef enum logic [1:0] {
        KIND_DOMAIN = 2'b00,
        KIND_TRANS  = 2'b01,
        KIND_PAGE   = 2'b10,
        KIND_PERM   = 2'b11
    } kind_e;

    // Programming port targets.
    typedef enum logic [1:0] {
        SEL_SECT = 2'd0,
        SEL_DCR  = 2'd1,
        SEL_PAGE = 2'd2,
        SEL_NONE = 2'd3
    } sel_e;

endpackage

// File: rtl/assoc_table.sv
// Module: assoc_table
// A small fully associative register table. Each entry holds a valid bit, a tag
// and a payload. The lookup compares the key against every entry in parallel and
// returns the payload of the lowest-indexed valid match.
// Assumes writes land on the clock edge and lookups are purely combinational.
// An index at or beyond DEPTH writes nothing.
module assoc_table #(
    parameter int DEPTH = 4,
    parameter int IDX_W = 3,
    parameter int TAG_W = 12,
    parameter int PAY_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_valid,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [PAY_W-1:0] wr_pay,
    input  logic [TAG_W-1:0] look_tag,
    output logic             hit,
    output logic [PAY_W-1:0] hit_pay
);

    logic [DEPTH-1:0] ent_valid;
    logic [TAG_W-1:0] ent_tag [DEPTH];
    logic [PAY_W-1:0] ent_pay [DEPTH];
    logic [DEPTH-1:0] match;

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        // Store one entry; reset clears it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_valid[i] <= 1'b0;
                ent_tag[i]   <= '0;
                ent_pay[i]   <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(i))) begin
                ent_valid[i] <= wr_valid;
                ent_tag[i]   <= wr_tag;
                ent_pay[i]   <= wr_pay;
            end
        end

        // Compare this entry against the lookup key.
        assign match[i] = ent_valid[i] && (ent_tag[i] == look_tag);
    end

    // Select the payload of the lowest-indexed match.
    always_comb begin
        hit     = |match;
        hit_pay = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit_pay = ent_pay[i];
            end
        end
    end

endmodule

// File: rtl/access_decide.sv
// Module: access_decide
// The combinational verdict for one access. It checks, in priority order:
//   1. section presence;
//   2. the domain-control field of the section's domain;
//   3. page presence;
//   4. the permission of the addressed 1 KB sub-page against the access direction.
// Assumes its inputs come from the section table, the control word and the page
// table of the same cycle. The clock and reset serve the embedded checks only.
module access_decide
    import dom_subpage_checker_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sect_hit,
    input  logic [DOM_W-1:0]   sect_dom,
    input  logic [DCR_W-1:0]   dcr,
    input  logic               page_hit,
    input  logic [PERMS_W-1:0] page_perms,
    input  logic [SUB_W-1:0]   sub_sel,
    input  logic               is_write,
    output logic               grant,
    output kind_e              kind
);

    logic [FIELD_W-1:0] dom_field;
    perm_e              sel_perm;
    logic               may_read;
    logic               may_write;

    // Pick the control field and the sub-page permission that apply.
    always_comb begin
        dom_field = dcr[sect_dom*FIELD_W +: FIELD_W];
        sel_perm  = perm_e'(page_perms[sub_sel*PERM_W +: PERM_W]);
        may_read  = (sel_perm == PERM_RO) || (sel_perm == PERM_RW);
        may_write = (sel_perm == PERM_RW);
    end

    // Apply the checks in priority order.
    always_comb begin
        grant = 1'b0;
        kind  = KIND_DOMAIN;
        if (!sect_hit) begin
            kind = KIND_TRANS;
        end else if (dom_field == 2'b00) begin
            kind = KIND_DOMAIN;
        end else if (!page_hit) begin
            kind = KIND_PAGE;
        end else if (is_write ? !may_write : !may_read) begin
            kind = KIND_PERM;
        end else begin
            grant = 1'b1;
        end
    end

    // R6
    grant_needs_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> (sect_hit && page_hit
                   && (dcr[sect_dom*FIELD_W +: FIELD_W] != 2'b00)
                   && (page_perms[sub_sel*PERM_W +: PERM_W] != 2'b00)
                   && (page_perms[sub_sel*PERM_W +: PERM_W] != 2'b11)));

    // R5
    write_grant_rw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && is_write) |-> (page_perms[sub_sel*PERM_W +: PERM_W] == 2'b10));

endmodule

// File: rtl/dom_subpage_checker.sv
// Module: dom_subpage_checker (top)
// Checks each access request against section domain ownership and 1 KB sub-page
// permissions, and registers the verdict one cycle after the request.
// The programming port loads the section table, the domain control word and the
// page table. A write is seen by requests issued in the following cycle.
// Assumes a single requester and no back-pressure on the response.
module dom_subpage_checker
    import dom_subpage_checker_pkg::*;
#(
    parameter int N_SECT = 4,
    parameter int N_PAGE = 8,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_we,
    input  logic [1:0]        prog_sel,
    input  logic [IDX_W-1:0]  prog_idx,
    input  logic [31:0]       prog_data,
    input  logic              req_valid,
    input  logic [31:0]       req_addr,
    input  logic              req_write,
    output logic              rsp_valid,
    output logic              rsp_grant,
    output logic [1:0]        rsp_kind,
    output logic [31:0]       rsp_addr
);

    localparam int SECT_VBIT = DOM_W;
    localparam int PAGE_VBIT = PERMS_W;

    logic               sect_we;
    logic               page_we;
    logic               dcr_we;
    logic [DCR_W-1:0]   dcr_q;
    logic               sect_hit;
    logic [DOM_W-1:0]   sect_dom;
    logic               page_hit;
    logic [PERMS_W-1:0] page_perms;
    logic               dec_grant;
    kind_e              dec_kind;

    // Decode the programming-port target.
    always_comb begin
        sect_we = prog_we && (sel_e'(prog_sel) == SEL_SECT);
        dcr_we  = prog_we && (sel_e'(prog_sel) == SEL_DCR);
        page_we = prog_we && (sel_e'(prog_sel) == SEL_PAGE);
    end

    // Hold the domain control word; reset gives all fields no-access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dcr_q <= '0;
        end else if (dcr_we) begin
            dcr_q <= prog_data[DCR_W-1:0];
        end
    end

    assoc_table #(
        .DEPTH (N_SECT),
        .IDX_W (IDX_W),
        .TAG_W (SECT_TAG_W),
        .PAY_W (DOM_W)
    ) i_sect_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (sect_we),
        .wr_idx   (prog_idx),
        .wr_valid (prog_data[SECT_VBIT]),
        .wr_tag   (prog_data[ADDR_W-1:SECT_SHIFT]),
        .wr_pay   (prog_data[DOM_W-1:0]),
        .look_tag (req_addr[ADDR_W-1:SECT_SHIFT]),
        .hit      (sect_hit),
        .hit_pay  (sect_dom)
    );

    assoc_table #(
        .DEPTH (N_PAGE),
        .IDX_W (IDX_W),
        .TAG_W (PAGE_TAG_W),
        .PAY_W (PERMS_W)
    ) i_page_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (page_we),
        .wr_idx   (prog_idx),
        .wr_valid (prog_data[PAGE_VBIT]),
        .wr_tag   (prog_data[ADDR_W-1:PAGE_SHIFT]),
        .wr_pay   (prog_data[PERMS_W-1:0]),
        .look_tag (req_addr[ADDR_W-1:PAGE_SHIFT]),
        .hit      (page_hit),
        .hit_pay  (page_perms)
    );

    access_decide i_decide (
        .clk        (clk),
        .rst_n      (rst_n),
        .sect_hit   (sect_hit),
        .sect_dom   (sect_dom),
        .dcr        (dcr_q),
        .page_hit   (page_hit),
        .page_perms (page_perms),
        .sub_sel    (req_addr[PAGE_SHIFT-1:SUB_SHIFT]),
        .is_write   (req_write),
        .grant      (dec_grant),
        .kind       (dec_kind)
    );

    // Register the verdict and the address one cycle after a valid request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_grant <= 1'b0;
            rsp_kind  <= 2'b00;
            rsp_addr  <= '0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_grant <= dec_grant;
                rsp_kind  <= dec_kind;
                rsp_addr  <= req_addr;
            end
        end
    end

    // R1
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (rsp_valid && (rsp_addr == $past(req_addr))));

    // R1
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R8
    dcr_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> ((dcr_q == '0) && !rsp_valid));

    // R6
    grant_kind_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_grant) |-> (rsp_kind == 2'b00));

endmodule

// File: tb/test_dom_subpage_checker.sv
`timescale 1ns/100ps
// Scoreboard bench: the driver tasks push expected responses into a queue, and a
// monitor pops and compares them on each falling edge while rsp_valid is high.
module test_dom_subpage_checker;

    localparam int IDX_W = 3;
    localparam logic [1:0] K_DOM = 2'b00, K_TRN = 2'b01, K_PAG = 2'b10, K_PRM = 2'b11;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             prog_we = 1'b0;
    logic [1:0]       prog_sel = 2'd0;
    logic [IDX_W-1:0] prog_idx = '0;
    logic [31:0]      prog_data = '0;
    logic             req_valid = 1'b0;
    logic [31:0]      req_addr = '0;
    logic             req_write = 1'b0;
    logic             rsp_valid;
    logic             rsp_grant;
    logic [1:0]       rsp_kind;
    logic [31:0]      rsp_addr;

    typedef struct {
        logic        grant;
        logic [1:0]  kind;
        logic [31:0] addr;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   failures = 0;
    bit   done = 1'b0;

    always #2.5 clk = ~clk;

    dom_subpage_checker #(.N_SECT(4), .N_PAGE(8), .IDX_W(IDX_W)) i_dom_subpage_checker (
        .clk(clk), .rst_n(rst_n),
        .prog_we(prog_we), .prog_sel(prog_sel), .prog_idx(prog_idx), .prog_data(prog_data),
        .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write),
        .rsp_valid(rsp_valid), .rsp_grant(rsp_grant), .rsp_kind(rsp_kind), .rsp_addr(rsp_addr)
    );

    // Monitor: compare each response with the oldest expected item.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                failures++;
                $display("FAIL R1: unexpected response addr=%h, expected none", rsp_addr);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (rsp_grant !== e.grant || rsp_kind !== e.kind || rsp_addr !== e.addr) begin
                    failures++;
                    $display("FAIL %s: got grant=%0d kind=%0d addr=%h, expected grant=%0d kind=%0d addr=%h",
                             e.tag, rsp_grant, rsp_kind, rsp_addr, e.grant, e.kind, e.addr);
                end
            end
        end
    end

    // Each task starts just after a rising edge and returns just after the next one.
    task automatic issue(input logic [31:0] a, input logic w, input logic g,
                         input logic [1:0] k, input string tag);
        exp_t e;
        e.grant = g; e.kind = k; e.addr = a; e.tag = tag;
        exp_q.push_back(e);
        req_valid = 1'b1; req_addr = a; req_write = w;
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic prog(input logic [1:0] sel, input logic [IDX_W-1:0] idx, input logic [31:0] d);
        prog_we = 1'b1; prog_sel = sel; prog_idx = idx; prog_data = d;
        @(posedge clk); #1;
        prog_we = 1'b0;
    endtask

    task automatic prog_with_req(input logic [1:0] sel, input logic [31:0] d,
                                 input logic [31:0] a, input logic g,
                                 input logic [1:0] k, input string tag);
        exp_t e;
        e.grant = g; e.kind = k; e.addr = a; e.tag = tag;
        exp_q.push_back(e);
        prog_we = 1'b1; prog_sel = sel; prog_idx = '0; prog_data = d;
        req_valid = 1'b1; req_addr = a; req_write = 1'b0;
        @(posedge clk); #1;
        prog_we = 1'b0; req_valid = 1'b0;
    endtask

    // Watchdog: end a hung run as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (rsp_valid !== 1'b0) begin
            failures++;
            $display("FAIL R8: rsp_valid=%0d after reset, expected 0", rsp_valid);
        end
        @(posedge clk); #1;

        // R8: empty tables after reset.
        issue(32'h0010_0000, 1'b0, 1'b0, K_TRN, "R8 tables empty");
        prog(2'd0, 3'd0, 32'h0010_0013);          // section 0x001, valid, domain 3
        issue(32'h0010_0400, 1'b0, 1'b0, K_DOM, "R3/R8 control reset denies");
        prog(2'd1, 3'd0, 32'h0000_0040);          // domain 3 = 01
        issue(32'h0010_0400, 1'b0, 1'b0, K_PAG, "R4 page missing");
        prog(2'd2, 3'd0, 32'h0010_01E4);          // subs: N, RO, RW, 11

        // R5/R6 over all four sub-pages, back to back.
        issue(32'h0010_0000, 1'b0, 1'b0, K_PRM, "R5 read no-access");
        issue(32'h0010_0004, 1'b1, 1'b0, K_PRM, "R5 write no-access");
        issue(32'h0010_0400, 1'b0, 1'b1, K_DOM, "R6 read read-only");
        issue(32'h0010_07FC, 1'b1, 1'b0, K_PRM, "R5 write read-only");
        issue(32'h0010_0800, 1'b0, 1'b1, K_DOM, "R6 read read-write");
        issue(32'h0010_0BF0, 1'b1, 1'b1, K_DOM, "R6 write read-write");
        issue(32'h0010_0C00, 1'b0, 1'b0, K_PRM, "R5 read code 11");
        issue(32'h0010_0C10, 1'b1, 1'b0, K_PRM, "R5 write code 11");
        issue(32'h0010_1000, 1'b0, 1'b0, K_PAG, "R4 other page same section");
        issue(32'h0020_0000, 1'b0, 1'b0, K_TRN, "R2 unmapped section");

        // Second section, domain 15.
        prog(2'd0, 3'd1, 32'h0020_001F);
        issue(32'h0020_0C00, 1'b1, 1'b0, K_DOM, "R3 domain beats missing page");
        prog(2'd1, 3'd0, 32'h4000_0040);
        issue(32'h0020_0C00, 1'b1, 1'b0, K_PAG, "R4 after domain 15 enabled");
        prog(2'd2, 3'd1, 32'h0020_01AA);
        issue(32'h0020_0C00, 1'b1, 1'b1, K_DOM, "R6 write all read-write page");
        issue(32'h0020_03FC, 1'b0, 1'b1, K_DOM, "R6 read sub-page 0");

        // R3: field codes 11 and 10 count as checked.
        prog(2'd1, 3'd0, 32'h0000_00C0);
        issue(32'h0010_0800, 1'b1, 1'b1, K_DOM, "R3 field 11");
        issue(32'h0020_0400, 1'b0, 1'b0, K_DOM, "R3 domain 15 field 00");
        prog(2'd1, 3'd0, 32'h8000_0080);
        issue(32'h0020_0400, 1'b0, 1'b1, K_DOM, "R3 field 10");

        // R7: same-cycle write sees old state; the next cycle sees the new one.
        prog_with_req(2'd1, 32'h0000_0000, 32'h0010_0800, 1'b1, K_DOM, "R7 same cycle old");
        issue(32'h0010_0800, 1'b0, 1'b0, K_DOM, "R7 next cycle new");
        issue(32'h0020_0400, 1'b0, 1'b0, K_DOM, "R7 control cleared");

        // R7: invalidation, ignored select and out-of-range index.
        prog(2'd1, 3'd0, 32'h4000_0040);
        prog(2'd0, 3'd0, 32'h0010_0003);
        issue(32'h0010_0800, 1'b0, 1'b0, K_TRN, "R7/R2 section invalidated");
        prog(2'd3, 3'd1, 32'h0000_0000);
        issue(32'h0020_0400, 1'b0, 1'b1, K_DOM, "R7 select 3 ignored");
        prog(2'd0, 3'd5, 32'h0030_0013);
        issue(32'h0030_0000, 1'b0, 1'b0, K_TRN, "R7 index beyond depth ignored");

        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            failures++;
            $display("FAIL R1: %0d responses missing, expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule